// File: doc/BRIEF.md
# Backup Supply Switch Controller

This block decides which rail feeds the always-on backup domain: the main supply or the battery. It applies one of four switching policies chosen by a 2-bit field. Its inputs are a brown-out comparator output (a digital main-supply-low flag), a power-good pin, and the brown-out settings that qualify a switch. It drives a registered supply-select line. It also issues single-cycle requests to enter or leave backup sleep, which the power manager acts on.

Only the automatic policy switches in both directions on its own. When the block is on battery under the idle or brown-out-only policy, a rising edge on the power-good pin can bring the domain back to the main supply. In every policy, a wake-enable bit decides whether a return to main also asks the device to leave backup sleep. The pin is synchronized inside the block. Each rising edge it sees is a single event.

Top module: `bss_ctrl`

## Requirements
- R1: After reset, sel_batt_o is 0 (main supply) and both request outputs are 0.
- R2: With policy 0 (no action), a low main supply never moves the domain off the main supply.
- R3: With policy 2 (forced battery), sel_batt_o is 1 one cycle after the policy is applied. No entry request is raised, and power-good pin edges are ignored.
- R4: With policy 1 (automatic), a main-low flag seen while on main sets sel_batt_o to 1 on the next clock. The same clock raises bkup_enter_o for exactly one cycle.
- R5: With policy 1, a cleared main-low flag seen while on battery returns sel_batt_o to 0 on the next clock. bkup_exit_o pulses for one cycle in that clock only if wake_en_i is 1.
- R6: With policy 3 (brown-out, one way), the block moves to battery and pulses bkup_enter_o only if main-low, the backup action bit and the watch-main bit are all 1. A restored main supply never returns it to main.
- R7: With policy 0 or 3 and pg_en_i set, a rising edge of pg_pin_i returns the domain from battery to main on the third clock after the edge. bkup_exit_o pulses only if wake_en_i is 1. The edge is ignored when pg_en_i is 0 or the policy is 1 or 2, and a pin held high produces no further event.
- R8: Changing the policy while on battery does not move the select output. The new policy acts only on its next qualifying event.
- R9: bkup_enter_o and bkup_exit_o are never high in the same cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 2 | Switching policy: 0 none, 1 automatic, 2 forced battery, 3 brown-out one way |
| wake_en_i | input | 1 | Leave backup sleep when the main supply is restored |
| pg_en_i | input | 1 | Enables return to main on power-good pin edges |
| pg_pin_i | input | 1 | Asynchronous power-good pin |
| main_low_i | input | 1 | Brown-out comparator reports main supply below threshold |
| bod_bkup_act_i | input | 1 | Brown-out action is enter backup |
| bod_watch_main_i | input | 1 | Comparator monitors the main supply (1) or the battery (0) |
| sel_batt_o | output | 1 | 1 selects the battery, 0 the main supply |
| bkup_enter_o | output | 1 | One-cycle request to enter backup sleep |
| bkup_exit_o | output | 1 | One-cycle request to leave backup sleep |

## Verification
Each policy gets the same main-low rise and fall. This shows which policies go to battery, which come back, and which stay put. Under policy 3, the comparator qualifiers are switched one at a time, so a missing condition in the brown-out path shows up. Power-good edges are applied under every policy, with the enable on and off and with the pin held high. This separates real returns from ignored edges and repeat events, and it also measures the three-cycle latency. Each return is repeated with wake-enable set and cleared, and the policy is changed while on battery to check that the select line holds.

// File: rtl/bss_pkg.sv
package bss_pkg;
    localparam int CFG_W = 2;

    typedef enum logic [CFG_W-1:0] {
        POL_NONE  = 2'd0,
        POL_AUTO  = 2'd1,
        POL_FORCE = 2'd2,
        POL_BOD   = 2'd3
    } pol_e;

    typedef struct packed {
        logic on_batt;
        logic enter_req;
        logic exit_req;
    } ctl_state_t;
endpackage

// File: rtl/bss_edge_sync.sv
module bss_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [LAST:0] chain;
        logic          prev;
    } sync_t;

    sync_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb begin
                st_d       = st_q;
                st_d.chain = pin_i;
                st_d.prev  = st_q.chain[LAST];
            end
        end else begin : g_many
            always_comb begin
                st_d       = st_q;
                st_d.chain = {st_q.chain[LAST-1:0], pin_i};
                st_d.prev  = st_q.chain[LAST];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.chain[LAST] & ~st_q.prev;

    p_single_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/bss_policy.sv
module bss_policy
    import bss_pkg::*;
(
    input  logic       [CFG_W-1:0] cfg_i,
    input  ctl_state_t             cur_i,
    input  logic                   main_low_i,
    input  logic                   bod_bkup_act_i,
    input  logic                   bod_watch_main_i,
    input  logic                   pg_rise_i,
    input  logic                   pg_en_i,
    input  logic                   wake_en_i,
    output ctl_state_t             nxt_o
);
    pol_e pol;
    logic go_batt, go_main, pg_back, forced;

    always_comb begin
        pol     = pol_e'(cfg_i);
        go_batt = 1'b0;
        go_main = 1'b0;
        forced  = 1'b0;
        unique case (pol)
            POL_AUTO: begin
                go_batt = !cur_i.on_batt && main_low_i;
                go_main = cur_i.on_batt && !main_low_i;
            end
            POL_FORCE: forced = 1'b1;
            POL_BOD:   go_batt = !cur_i.on_batt && main_low_i
                                 && bod_bkup_act_i && bod_watch_main_i;
            default: ;
        endcase
        pg_back = cur_i.on_batt && pg_en_i && pg_rise_i
                  && (pol != POL_AUTO) && (pol != POL_FORCE);

        nxt_o = cur_i;
        if (forced || go_batt)       nxt_o.on_batt = 1'b1;
        else if (go_main || pg_back) nxt_o.on_batt = 1'b0;
        nxt_o.enter_req = go_batt;
        nxt_o.exit_req  = (go_main || pg_back) && wake_en_i;
    end
endmodule

// File: rtl/bss_ctrl.sv
module bss_ctrl
    import bss_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             wake_en_i,
    input  logic             pg_en_i,
    input  logic             pg_pin_i,
    input  logic             main_low_i,
    input  logic             bod_bkup_act_i,
    input  logic             bod_watch_main_i,
    output logic             sel_batt_o,
    output logic             bkup_enter_o,
    output logic             bkup_exit_o
);
    ctl_state_t st_d, st_q;
    logic       pg_rise;

    bss_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pg_pin_i),
        .rise_o (pg_rise)
    );

    bss_policy u_pol (
        .cfg_i            (cfg_i),
        .cur_i            (st_q),
        .main_low_i       (main_low_i),
        .bod_bkup_act_i   (bod_bkup_act_i),
        .bod_watch_main_i (bod_watch_main_i),
        .pg_rise_i        (pg_rise),
        .pg_en_i          (pg_en_i),
        .wake_en_i        (wake_en_i),
        .nxt_o            (st_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_batt_o   = st_q.on_batt;
    assign bkup_enter_o = st_q.enter_req;
    assign bkup_exit_o  = st_q.exit_req;

    p_idle_holds_main_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i == 2'd0 && !sel_batt_o) |=> !sel_batt_o);
    p_force_battery_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i == 2'd2) |=> (sel_batt_o && !bkup_enter_o));
    p_enter_on_switch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bkup_enter_o |-> (sel_batt_o && !$past(sel_batt_o)));
    p_auto_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i == 2'd1 && sel_batt_o && !main_low_i) |=> !sel_batt_o);
    p_exit_needs_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bkup_exit_o |-> ($past(wake_en_i) && !sel_batt_o));
    p_bod_one_way_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i == 2'd3 && sel_batt_o && !pg_rise) |=> sel_batt_o);
    p_req_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bkup_enter_o && bkup_exit_o));
endmodule

// File: tb/sim_bss_ctrl.sv
module sim_bss_ctrl;
    localparam time CLK_PERIOD = 10ns;

    typedef struct {
        logic  sel;
        logic  ent;
        logic  ext;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg = 2'd0;
    logic       wake = 1'b0, pg_en = 1'b0, pg_pin = 1'b0, mlow = 1'b0;
    logic       act = 1'b0, watch = 1'b0;
    logic       sel, ent, ext;

    int   checks = 0, errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    bss_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .wake_en_i(wake),
        .pg_en_i(pg_en), .pg_pin_i(pg_pin), .main_low_i(mlow),
        .bod_bkup_act_i(act), .bod_watch_main_i(watch),
        .sel_batt_o(sel), .bkup_enter_o(ent), .bkup_exit_o(ext)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input logic s, input logic e, input logic x, input string tag);
        exp_t it;
        it.sel = s; it.ent = e; it.ext = x; it.tag = tag;
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // monitor: pops one expected item per cycle and compares
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            checks++;
            if ({sel, ent, ext} !== {it.sel, it.ent, it.ext}) begin
                errors++;
                $display("FAIL %s: got sel=%b enter=%b exit=%b, expected sel=%b enter=%b exit=%b",
                         it.tag, sel, ent, ext, it.sel, it.ent, it.ext);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        tick(0,0,0,"R1"); tick(0,0,0,"R1");
        // R2 no action ignores low main
        mlow = 1'b1;
        tick(0,0,0,"R2"); tick(0,0,0,"R2");
        // R4 automatic to battery
        cfg = 2'd1;
        tick(1,1,0,"R4"); tick(1,0,0,"R9 single pulse");
        // R5 return with wake
        wake = 1'b1; mlow = 1'b0;
        tick(0,0,1,"R5 wake"); tick(0,0,0,"R9 single pulse");
        // R5 return without wake
        wake = 1'b0; mlow = 1'b1;
        tick(1,1,0,"R4"); mlow = 1'b0;
        tick(0,0,0,"R5 no wake");
        // R3 forced battery, pin edge ignored
        cfg = 2'd2;
        tick(1,0,0,"R3"); pg_en = 1'b1; pg_pin = 1'b1;
        tick(1,0,0,"R3"); tick(1,0,0,"R3"); tick(1,0,0,"R3"); tick(1,0,0,"R3");
        pg_pin = 1'b0;
        tick(1,0,0,"R3"); tick(1,0,0,"R3"); tick(1,0,0,"R3");
        // R8 policy change while on battery holds select
        cfg = 2'd0;
        tick(1,0,0,"R8"); tick(1,0,0,"R8");
        // R7 pin edge returns after three clocks, with wake
        wake = 1'b1; pg_pin = 1'b1;
        tick(1,0,0,"R7 latency"); tick(1,0,0,"R7 latency"); tick(0,0,1,"R7");
        tick(0,0,0,"R7 held pin"); tick(0,0,0,"R7 held pin");
        pg_pin = 1'b0;
        tick(0,0,0,"R7"); tick(0,0,0,"R7"); tick(0,0,0,"R7");
        // R6 brown-out policy qualifiers
        cfg = 2'd3; act = 1'b1; watch = 1'b0; mlow = 1'b1;
        tick(0,0,0,"R6 watch batt"); act = 1'b0; watch = 1'b1;
        tick(0,0,0,"R6 no action"); act = 1'b1;
        tick(1,1,0,"R6"); mlow = 1'b0;
        tick(1,0,0,"R6 one way"); tick(1,0,0,"R6 one way");
        // R7 edge ignored when disabled
        pg_en = 1'b0; pg_pin = 1'b1;
        tick(1,0,0,"R7 disabled"); tick(1,0,0,"R7 disabled");
        tick(1,0,0,"R7 disabled"); tick(1,0,0,"R7 disabled");
        pg_pin = 1'b0;
        tick(1,0,0,"R6"); tick(1,0,0,"R6"); tick(1,0,0,"R6");
        // R7 edge under policy 3 without wake
        pg_en = 1'b1; wake = 1'b0; pg_pin = 1'b1;
        tick(1,0,0,"R7 latency"); tick(1,0,0,"R7 latency"); tick(0,0,0,"R7 no wake");
        pg_pin = 1'b0;
        tick(0,0,0,"R7"); tick(0,0,0,"R7"); tick(0,0,0,"R7");
        // R7 edge ignored in automatic policy
        cfg = 2'd1; mlow = 1'b1;
        tick(1,1,0,"R4"); pg_pin = 1'b1;
        tick(1,0,0,"R7 auto"); tick(1,0,0,"R7 auto"); tick(1,0,0,"R7 auto"); tick(1,0,0,"R7 auto");
        // R8 move to policy 3 on battery: restore does not return
        cfg = 2'd3; mlow = 1'b0;
        tick(1,0,0,"R8"); tick(1,0,0,"R8");
        // back to automatic: restore returns
        cfg = 2'd1; wake = 1'b1;
        tick(0,0,1,"R8 R5"); tick(0,0,0,"R9");
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule